// File: doc/BRIEF.md
# Start-Bit-Framed Serial Command Receiver

This block is the device end of a three-wire serial command link: an active-low select, a serial clock and a data line. The three pins are brought into the system clock domain through two-flop synchronizers, and rising edges of the serial clock are found there. One data bit is taken on each rising serial-clock edge while select is low. This is the usual mode-0 arrangement: the clock idles low and data is sampled on the rising edge.

Framing is not counted from the select edge. While the receiver is hunting, it drops any run of zero bits. The first 1 it samples becomes the most significant bit of an 8-bit command, and the next seven bits complete it. The finished command is split into a channel number, a unipolar flag, a single-ended flag and a two-bit power/clock mode. These fields are registered and held for downstream logic, and a one-cycle strobe marks each new command. Several commands may follow each other within one select window. Raising select throws away a partial command, and a new falling edge starts a fresh hunt.

Top module: `startbit_cmd_rx`

## Requirements
- R1: A synchronous reset drives `valid_o` low, drives every decoded field to zero, and returns the receiver to hunting for a start bit.
- R2: While hunting with select low, zero bits have no effect however many arrive. The first 1 sampled is taken as bit 7 of the command.
- R3: The command is received most significant bit first. Its bits 6:4 give `chan_o`, bit 3 gives `unipolar_o` (1 = unipolar, 0 = bipolar), bit 2 gives `single_o` (1 = single-ended, 0 = differential), and bits 1:0 give `mode_o`. The mode codes are 00 full power-down, 01 fast power-down, 10 internal clock and 11 external clock.
- R4: Each completed command raises `valid_o` for exactly one system clock cycle. `valid_o` rises on the fourth rising system-clock edge after the input serial clock rises with the eighth bit.
- R5: If select goes high before eight bits have arrived, the partial command is dropped. No strobe is issued and the fields keep their old values.
- R6: After a command completes with select still low, the receiver hunts again, skips zeros, and decodes the next command in the same way.
- R7: The decoded fields hold their values until the next complete command. Serial clock edges while select is high have no effect.
- R8: A falling edge on select starts a new hunt. Bits received before a dropped partial command play no part in the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n_i | input | 1 | Active-low select, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous, idles low |
| din_i | input | 1 | Serial data, asynchronous |
| valid_o | output | 1 | One-cycle strobe for a new command |
| chan_o | output | 3 | Decoded channel number |
| unipolar_o | output | 1 | 1 = unipolar, 0 = bipolar |
| single_o | output | 1 | 1 = single-ended, 0 = differential |
| mode_o | output | 2 | Power/clock mode code |

## Verification
An input serial-clock rise passes through two synchronizer flops and then the edge compare. The framer registers its completion pulse on the third system edge, and the decoder registers the fields and the strobe on the fourth. The bench drives every pin on a falling system edge and samples on falling edges. It expects `valid_o` high at exactly the fourth sample after the last bit's clock rise and low at the samples on either side. Field and strobe-count checks wait until several cycles after select has returned high, when every register on the path has settled.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

    localparam int CMD_W     = 8;
    localparam int CHAN_W    = 3;
    localparam int MODE_W    = 2;
    localparam int CNT_W     = $clog2(CMD_W);

    localparam int START_POS = CMD_W - 1;
    localparam int CHAN_LSB  = 4;
    localparam int UNI_POS   = 3;
    localparam int SGL_POS   = 2;
    localparam int MODE_LSB  = 0;

    typedef enum logic [MODE_W-1:0] {
        PM_FULL_DOWN = 2'b00,
        PM_FAST_DOWN = 2'b01,
        PM_INT_CLK   = 2'b10,
        PM_EXT_CLK   = 2'b11
    } pmode_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              unipolar;
        logic              single;
        pmode_e            mode;
    } cmd_t;

    typedef enum logic {
        FR_HUNT  = 1'b0,
        FR_SHIFT = 1'b1
    } frame_e;

endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_d;
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                stg_d[0] = d_i;
            end
        end else begin : g_chain
            always_comb begin
                stg_d = {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cmdrx_front.sv
module cmdrx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic cs_act_o,
    output logic cs_fall_o,
    output logic sclk_rise_o,
    output logic din_o
);

    typedef struct packed {
        logic sclk_p;
        logic csn_p;
    } front_t;

    logic [2:0] raw_s;
    logic       csn_s;
    logic       sclk_s;
    logic       din_s;
    front_t     fr_d;
    front_t     fr_q;

    cmdrx_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({cs_n_i, sclk_i, din_i}),
        .q_o (raw_s)
    );

    assign csn_s  = raw_s[2];
    assign sclk_s = raw_s[1];
    assign din_s  = raw_s[0];

    always_comb begin
        fr_d        = fr_q;
        fr_d.sclk_p = sclk_s;
        fr_d.csn_p  = csn_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q.sclk_p <= 1'b0;
            fr_q.csn_p  <= 1'b1;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign cs_act_o    = ~csn_s;
    assign cs_fall_o   = ~csn_s & fr_q.csn_p;
    assign sclk_rise_o = sclk_s & ~fr_q.sclk_p;
    assign din_o       = din_s;

    // A detected serial-clock edge lasts one system cycle (feeds R4 pulse width)
    assert_rise_single_R4: assert property (@(posedge clk) disable iff (rst)
        sclk_rise_o |=> !sclk_rise_o);

    // A select fall cannot repeat on the next cycle (R8)
    assert_fall_single_R8: assert property (@(posedge clk) disable iff (rst)
        cs_fall_o |=> !cs_fall_o);

endmodule

// File: rtl/cmdrx_framer.sv
module cmdrx_framer
    import cmdrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_act_i,
    input  logic             cs_fall_i,
    input  logic             rise_i,
    input  logic             din_i,
    output logic             done_o,
    output logic [CMD_W-1:0] byte_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CMD_W - 1);
    localparam logic [CMD_W-1:0] START_SEED = CMD_W'(1);

    typedef struct packed {
        frame_e             state;
        logic [CNT_W-1:0]   cnt;
        logic [CMD_W-1:0]   shreg;
        logic               done;
        logic [CMD_W-1:0]   cmd_byte;
    } framer_t;

    framer_t fm_d;
    framer_t fm_q;

    always_comb begin
        fm_d      = fm_q;
        fm_d.done = 1'b0;
        if (!cs_act_i || cs_fall_i) begin
            fm_d.state = FR_HUNT;
            fm_d.cnt   = '0;
            fm_d.shreg = '0;
        end else if (rise_i) begin
            unique case (fm_q.state)
                FR_HUNT: begin
                    if (din_i) begin
                        fm_d.shreg = START_SEED;
                        fm_d.cnt   = CNT_W'(1);
                        fm_d.state = FR_SHIFT;
                    end
                end
                FR_SHIFT: begin
                    fm_d.shreg = {fm_q.shreg[CMD_W-2:0], din_i};
                    if (fm_q.cnt == LAST_IDX) begin
                        fm_d.done     = 1'b1;
                        fm_d.cmd_byte = {fm_q.shreg[CMD_W-2:0], din_i};
                        fm_d.state    = FR_HUNT;
                        fm_d.cnt      = '0;
                    end else begin
                        fm_d.cnt = fm_q.cnt + CNT_W'(1);
                    end
                end
                default: fm_d.state = FR_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fm_q.state    <= FR_HUNT;
            fm_q.cnt      <= '0;
            fm_q.shreg    <= '0;
            fm_q.done     <= 1'b0;
            fm_q.cmd_byte <= '0;
        end else begin
            fm_q <= fm_d;
        end
    end

    assign done_o = fm_q.done;
    assign byte_o = fm_q.cmd_byte;

    // Every assembled command carries the start bit in its top position
    assert_start_msb_R2: assert property (@(posedge clk) disable iff (rst)
        fm_q.done |-> fm_q.cmd_byte[START_POS]);

    // Completion is a single-cycle event
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        fm_q.done |=> !fm_q.done);

    // Select high leaves the framer hunting with nothing pending
    assert_idle_drop_R5: assert property (@(posedge clk) disable iff (rst)
        !cs_act_i |=> (fm_q.state == FR_HUNT && fm_q.cnt == '0 && !fm_q.done));

    // A select fall always restarts the hunt
    assert_fall_hunt_R8: assert property (@(posedge clk) disable iff (rst)
        cs_fall_i |=> (fm_q.state == FR_HUNT && !fm_q.done));

    // While hunting, a zero bit changes nothing
    assert_zero_skip_R2: assert property (@(posedge clk) disable iff (rst)
        (cs_act_i && !cs_fall_i && rise_i && !din_i && fm_q.state == FR_HUNT)
        |=> (fm_q.state == FR_HUNT && fm_q.cnt == '0));

endmodule

// File: rtl/cmdrx_decode.sv
module cmdrx_decode
    import cmdrx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic [CMD_W-1:0] byte_i,
    output logic             valid_o,
    output cmd_t             cmd_o
);

    typedef struct packed {
        cmd_t cmd;
        logic valid;
    } dec_t;

    dec_t dc_d;
    dec_t dc_q;
    logic load;

    assign load = done_i & byte_i[START_POS];

    always_comb begin
        dc_d       = dc_q;
        dc_d.valid = load;
        if (load) begin
            dc_d.cmd.chan     = byte_i[CHAN_LSB +: CHAN_W];
            dc_d.cmd.unipolar = byte_i[UNI_POS];
            dc_d.cmd.single   = byte_i[SGL_POS];
            dc_d.cmd.mode     = pmode_e'(byte_i[MODE_LSB +: MODE_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dc_q <= '0;
        end else begin
            dc_q <= dc_d;
        end
    end

    assign valid_o = dc_q.valid;
    assign cmd_o   = dc_q.cmd;

    // Reset leaves strobe low and fields cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (!dc_q.valid && dc_q.cmd == '0));

    // Strobe never lasts two cycles
    assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        dc_q.valid |=> !dc_q.valid);

    // A completed command lands in the fields one cycle later
    assert_field_load_R3: assert property (@(posedge clk) disable iff (rst)
        load |=> (dc_q.valid && dc_q.cmd.chan == $past(byte_i[CHAN_LSB +: CHAN_W])
                  && dc_q.cmd.mode == $past(byte_i[MODE_LSB +: MODE_W])));

    // Without a completed command the fields hold
    assert_field_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dc_q.cmd));

endmodule

// File: rtl/startbit_cmd_rx.sv
module startbit_cmd_rx
    import cmdrx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n_i,
    input  logic       sclk_i,
    input  logic       din_i,
    output logic       valid_o,
    output logic [2:0] chan_o,
    output logic       unipolar_o,
    output logic       single_o,
    output logic [1:0] mode_o
);

    logic             cs_act;
    logic             cs_fall;
    logic             sclk_rise;
    logic             din_s;
    logic             frame_done;
    logic [CMD_W-1:0] frame_byte;
    cmd_t             cmd;

    cmdrx_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) front_i (
        .clk         (clk),
        .rst         (rst),
        .cs_n_i      (cs_n_i),
        .sclk_i      (sclk_i),
        .din_i       (din_i),
        .cs_act_o    (cs_act),
        .cs_fall_o   (cs_fall),
        .sclk_rise_o (sclk_rise),
        .din_o       (din_s)
    );

    cmdrx_framer framer_i (
        .clk       (clk),
        .rst       (rst),
        .cs_act_i  (cs_act),
        .cs_fall_i (cs_fall),
        .rise_i    (sclk_rise),
        .din_i     (din_s),
        .done_o    (frame_done),
        .byte_o    (frame_byte)
    );

    cmdrx_decode decode_i (
        .clk     (clk),
        .rst     (rst),
        .done_i  (frame_done),
        .byte_i  (frame_byte),
        .valid_o (valid_o),
        .cmd_o   (cmd)
    );

    assign chan_o     = cmd.chan;
    assign unipolar_o = cmd.unipolar;
    assign single_o   = cmd.single;
    assign mode_o     = cmd.mode;

    // A strobe only follows a framer completion one cycle earlier (R4)
    assert_strobe_source_R4: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(frame_done));

endmodule

// File: tb/startbit_cmd_rx_tb_top.sv
module startbit_cmd_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       valid_o;
    logic [2:0] chan_o;
    logic       unipolar_o;
    logic       single_o;
    logic [1:0] mode_o;

    int n_checks = 0;
    int n_errors = 0;
    int vcount   = 0;

    always #5 clk = ~clk;

    startbit_cmd_rx dut_i (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (cs_n),
        .sclk_i     (sclk),
        .din_i      (din),
        .valid_o    (valid_o),
        .chan_o     (chan_o),
        .unipolar_o (unipolar_o),
        .single_o   (single_o),
        .mode_o     (mode_o)
    );

    always @(negedge clk) begin
        if (!rst && valid_o === 1'b1) vcount++;
    end

    localparam int NVEC = 6;
    localparam logic [7:0] VEC_BYTE [NVEC] = '{8'h80, 8'hFF, 8'hA5, 8'hDA, 8'hB3, 8'hC8};
    localparam int         VEC_LEAD [NVEC] = '{0, 3, 1, 7, 2, 12};

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Field layout per R3: [6:4] channel, [3] unipolar, [2] single-ended, [1:0] mode
    task automatic chk_fields(input string req, input logic [7:0] b);
        chk(req, "chan",     {29'd0, chan_o},     {29'd0, b[6:4]});
        chk(req, "unipolar", {31'd0, unipolar_o}, {31'd0, b[3]});
        chk(req, "single",   {31'd0, single_o},   {31'd0, b[2]});
        chk(req, "mode",     {30'd0, mode_o},     {30'd0, b[1:0]});
    endtask

    task automatic send_bit(input logic b, input bit chk_lat);
        din = b;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (chk_lat) chk("R4", $sformatf("valid at sample %0d", k),
                             {31'd0, valid_o}, {31'd0, (k == 4)});
        end
        sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0, 1'b0);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit chk_lat);
        for (int i = 7; i >= 0; i--) send_bit(b[i], chk_lat && (i == 0));
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        din  = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R4 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "valid after reset", {31'd0, valid_o}, 32'd0);
        chk_fields("R1", 8'h00);

        // R2/R3/R4: table of commands with varying leading zeros
        for (int i = 0; i < NVEC; i++) begin
            v0 = vcount;
            cs_low();
            send_zeros(VEC_LEAD[i]);
            send_byte(VEC_BYTE[i], (i == 0) || (i == 3));
            cs_high();
            chk("R4", $sformatf("strobe count vec %0d", i), vcount - v0, 32'd1);
            chk_fields($sformatf("R2 R3 vec %0d", i), VEC_BYTE[i]);
        end

        // R6: two commands in one select window, zeros between
        v0 = vcount;
        cs_low();
        send_byte(8'hA5, 1'b0);
        repeat (2) @(negedge clk);
        chk_fields("R6 first", 8'hA5);
        send_zeros(2);
        send_byte(8'hDA, 1'b1);
        cs_high();
        chk("R6", "strobe count", vcount - v0, 32'd2);
        chk_fields("R6 second", 8'hDA);

        // R5: select rises after five bits
        v0 = vcount;
        cs_low();
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        cs_high();
        chk("R5", "no strobe for partial", vcount - v0, 32'd0);
        chk_fields("R5 held", 8'hDA);

        // R7: serial clocks with select high
        v0 = vcount;
        for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0);
        repeat (8) @(negedge clk);
        chk("R7", "no strobe while deselected", vcount - v0, 32'd0);
        chk_fields("R7 held", 8'hDA);

        // R8: partial, brief deselect, then a fresh command
        v0 = vcount;
        cs_low();
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        cs_high();
        cs_low();
        send_zeros(2);
        send_byte(8'h93, 1'b0);
        cs_high();
        chk("R8", "strobe count", vcount - v0, 32'd1);
        chk_fields("R8", 8'h93);

        // R1: reset in the middle of operation clears fields
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "valid after mid reset", {31'd0, valid_o}, 32'd0);
        chk_fields("R1 mid", 8'h00);

        finish_run();
    end

endmodule